// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block sends stereo audio samples out over a three-wire port made of a bit clock, a word clock and a serial data line. The whole block runs from one system clock at 256 times the sample rate. In master mode it drives both port clocks itself. The bit clock is that system clock divided by four, which gives 64 bit clocks per sample period and 32 bit slots per channel. In slave mode it takes both clocks as inputs. It brings them into its own clock domain and follows their edges. In slave mode the bit clock may stop, and the word clock need not have a 50% duty cycle.

Static configuration inputs set the following:
- sample length
- left or right alignment inside the channel phase
- a one-slot delay of the first bit
- the polarity of each port clock

A direct-frame mode sends the three per-channel status flags in the slots after the audio. It also sends a block-start marker in the slot where a parity bit would otherwise be. A mute input forces the data line to zero from the next bit slot on. Right alignment cannot be used in slave mode. If it is requested there, the block uses left alignment instead.

Top module: `sao_tx`

## Requirements
- R1: In master mode `sck_out` has a period of 4 `clk` cycles. `wck_out` stays in each phase for 128 `clk` cycles, which is 32 bit slots. Every `wck_out` change happens together with a data change.
- R2: `cfg_res` selects the sample length: 0 gives 16 bits, 1 gives 20 bits, 2 and 3 give 24 bits. The sample is taken MSB first from bit 23 of the 24-bit input downward. Every slot that does not carry a sample bit is driven to 0.
- R3: With `cfg_dly`=1 in left alignment, slot 0 carries 0 and the MSB moves to slot 1.
- R4: With `cfg_rjust`=1 in master mode, the LSB of the sample falls in slot 31, and `cfg_dly` has no effect.
- R5: The left sample is sent while `wck_out ^ cfg_wpol` is 0, and the right sample while it is 1.
- R6: `sdata` changes only at the falling edge of the normalised bit clock (`sck ^ cfg_bpol`), so it is stable at the rising edge.
- R7: With `cfg_direct`=1, slots first..first+23 carry the 24 sample bits, where first equals `cfg_dly`. The next four slots carry V, U and C (`stat_*[2]`, `[1]`, `[0]`) and then Z (`blk_start`). `cfg_res` and `cfg_rjust` are ignored in this mode.
- R8: When `cfg_mute`=1, every bit slot that starts after it is asserted carries 0.
- R9: In slave mode (`cfg_master`=0), `sck_in` and `wck_in` set the timing. The first bit slot after a word clock change is slot 0. `sck_out` and `wck_out` are held at 0. After reset `sdata` is 0.
- R10: In slave mode a request for right alignment produces left-aligned output.
- R11: In slave mode a word clock phase that holds fewer than 32 bit clocks still carries all the sample bits that fit in it.
- R12: A channel's sample and status are latched when its phase begins. Input changes during the phase do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256x sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1 = generate port clocks, 0 = follow port clocks |
| cfg_res | input | 2 | Sample length code (0:16, 1:20, 2/3:24) |
| cfg_rjust | input | 1 | Right alignment request (master only) |
| cfg_dly | input | 1 | One-slot delay of the first bit |
| cfg_bpol | input | 1 | Bit clock inversion |
| cfg_wpol | input | 1 | Word clock inversion |
| cfg_mute | input | 1 | Force data to zero |
| cfg_direct | input | 1 | Send status flags and block marker after the audio |
| smp_left | input | 24 | Left sample, MSB-aligned |
| smp_right | input | 24 | Right sample, MSB-aligned |
| stat_left | input | 3 | Left {V,U,C} flags |
| stat_right | input | 3 | Right {V,U,C} flags |
| blk_start | input | 1 | Block-start marker for the current frame |
| sck_in | input | 1 | Bit clock from the port (slave) |
| wck_in | input | 1 | Word clock from the port (slave) |
| sck_out | output | 1 | Bit clock to the port (master) |
| wck_out | output | 1 | Word clock to the port (master) |
| sdata | output | 1 | Serial data |

## Verification
The bench decodes each channel phase at the port and checks where the first and last sample bits land. A design that miscounts the delay or the right-alignment offset shifts the whole word by one or more slots. A design that wrongly accepts right alignment in slave mode sends a word that ends late. The bench asserts mute in the middle of a word and changes an input sample in the middle of a phase. A late mute lets extra sample bits through, and a missing latch corrupts the tail of the word. In slave mode the bench uses a short word clock phase and inverted clock polarities. This catches phase counting that runs from the wrong edge and a channel swap under inverted polarity.

// File: rtl/sao_pkg.sv
package sao_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SLOTS    = 32;
  localparam int STAT_W   = 3;

  typedef enum logic [1:0] {
    RES_16  = 2'd0,
    RES_20  = 2'd1,
    RES_24  = 2'd2,
    RES_24X = 2'd3
  } res_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] smp;
    logic                v;
    logic                u;
    logic                c;
    logic                z;
  } chan_word_t;

  function automatic int res_len(input logic [1:0] code);
    case (res_e'(code))
      RES_16:  return 16;
      RES_20:  return 20;
      default: return SAMPLE_W;
    endcase
  endfunction

  // Value carried in slot `pos` of a channel phase.
  function automatic logic slot_bit(input logic [5:0] pos, input chan_word_t w,
                                    input logic [1:0] res, input logic rj,
                                    input logic dly, input logic direct);
    int n;
    int first;
    int k;
    if (direct) begin
      n     = SAMPLE_W + 4;
      first = int'(dly);
    end else begin
      n     = res_len(res);
      first = rj ? (SLOTS - n) : int'(dly);
    end
    k = int'(pos) - first;
    if (k < 0 || k >= n) return 1'b0;
    if (k < SAMPLE_W) return w.smp[SAMPLE_W-1-k];
    case (k - SAMPLE_W)
      0:       return w.v;
      1:       return w.u;
      2:       return w.c;
      default: return w.z;
    endcase
  endfunction

endpackage

// File: rtl/sao_clkgen.sv
module sao_clkgen #(
  parameter int DIV_LOG2 = 2,
  parameter int SLOT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              sck_lvl,
  output logic              wck_lvl,
  output logic              adv,
  output logic [SLOT_W-1:0] slot_nxt
);

  logic [DIV_LOG2-1:0] div_q;
  logic [SLOT_W-1:0]   slot_q;

  assign adv      = en && (div_q == '1);
  assign slot_nxt = slot_q + 1'b1;
  assign sck_lvl  = div_q[DIV_LOG2-1];
  assign wck_lvl  = slot_q[SLOT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      div_q  <= '0;
      slot_q <= '1;
    end else begin
      div_q <= div_q + 1'b1;
      if (adv) slot_q <= slot_nxt;
    end
  end

endmodule

// File: rtl/sao_slave_sync.sv
module sao_slave_sync #(
  parameter int SYNC  = 2,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sck_pin,
  input  logic             wck_pin,
  input  logic             bpol,
  input  logic             wpol,
  output logic             adv,
  output logic             new_chan,
  output logic             chan,
  output logic [POS_W-1:0] pos_nxt
);

  logic [SYNC-1:0]  sck_sr;
  logic [SYNC-1:0]  wck_sr;
  logic             sck_prev;
  logic             last_ph;
  logic [POS_W-1:0] pos_q;

  assign chan     = wck_sr[SYNC-1];
  assign adv      = en && sck_prev && !sck_sr[SYNC-1];
  assign new_chan = (chan != last_ph);
  assign pos_nxt  = new_chan ? '0 : ((pos_q == '1) ? pos_q : pos_q + 1'b1);

  genvar g;
  generate
    for (g = 0; g < SYNC; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sck_sr[g] <= 1'b0;
          wck_sr[g] <= 1'b0;
        end else if (g == 0) begin
          sck_sr[g] <= sck_pin ^ bpol;
          wck_sr[g] <= wck_pin ^ wpol;
        end else begin
          sck_sr[g] <= sck_sr[(g == 0) ? 0 : g-1];
          wck_sr[g] <= wck_sr[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      last_ph  <= 1'b1;
      pos_q    <= '1;
    end else begin
      sck_prev <= sck_sr[SYNC-1];
      if (adv) begin
        last_ph <= chan;
        pos_q   <= pos_nxt;
      end
    end
  end

endmodule

// File: rtl/sao_serializer.sv
module sao_serializer
  import sao_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                new_chan,
  input  logic                chan,
  input  logic [5:0]          pos,
  input  logic [1:0]          res,
  input  logic                rj,
  input  logic                dly,
  input  logic                direct,
  input  logic                mute,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic [STAT_W-1:0]   stat_l,
  input  logic [STAT_W-1:0]   stat_r,
  input  logic                blk,
  output logic                sdata
);

  chan_word_t held_q;
  chan_word_t incoming;
  chan_word_t src;

  assign incoming = chan ? {smp_r, stat_r, blk} : {smp_l, stat_l, blk};
  assign src      = new_chan ? incoming : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      sdata  <= 1'b0;
    end else if (adv) begin
      if (new_chan) held_q <= incoming;
      sdata <= mute ? 1'b0 : slot_bit(pos, src, res, rj, dly, direct);
    end
  end

endmodule

// File: rtl/sao_tx.sv
module sao_tx
  import sao_pkg::*;
#(
  parameter int DIV_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic [1:0]          cfg_res,
  input  logic                cfg_rjust,
  input  logic                cfg_dly,
  input  logic                cfg_bpol,
  input  logic                cfg_wpol,
  input  logic                cfg_mute,
  input  logic                cfg_direct,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [STAT_W-1:0]   stat_left,
  input  logic [STAT_W-1:0]   stat_right,
  input  logic                blk_start,
  input  logic                sck_in,
  input  logic                wck_in,
  output logic                sck_out,
  output logic                wck_out,
  output logic                sdata
);

  localparam int SLOT_W = $clog2(SLOTS) + 1;

  logic              m_sck, m_wck, m_adv;
  logic [SLOT_W-1:0] m_slot;
  logic              s_adv, s_new, s_chan;
  logic [5:0]        s_pos;

  // Named events shared with the checker
  logic       bit_adv;
  logic       chan_new;
  logic       chan_sel;
  logic [5:0] slot_pos;
  logic       rj_eff;

  sao_clkgen #(.DIV_LOG2(DIV_LOG2), .SLOT_W(SLOT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(cfg_master),
    .sck_lvl(m_sck), .wck_lvl(m_wck), .adv(m_adv), .slot_nxt(m_slot)
  );

  sao_slave_sync #(.SYNC(SYNC_STAGES), .POS_W(6)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(!cfg_master),
    .sck_pin(sck_in), .wck_pin(wck_in), .bpol(cfg_bpol), .wpol(cfg_wpol),
    .adv(s_adv), .new_chan(s_new), .chan(s_chan), .pos_nxt(s_pos)
  );

  always_comb begin
    if (cfg_master) begin
      bit_adv  = m_adv;
      chan_new = (m_slot[SLOT_W-2:0] == '0);
      chan_sel = m_slot[SLOT_W-1];
      slot_pos = 6'(m_slot[SLOT_W-2:0]);
    end else begin
      bit_adv  = s_adv;
      chan_new = s_new;
      chan_sel = s_chan;
      slot_pos = s_pos;
    end
  end

  // Right alignment needs a known phase length, so only master honours it
  assign rj_eff = cfg_rjust & cfg_master;

  sao_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .adv(bit_adv), .new_chan(chan_new),
    .chan(chan_sel), .pos(slot_pos), .res(cfg_res), .rj(rj_eff),
    .dly(cfg_dly), .direct(cfg_direct), .mute(cfg_mute),
    .smp_l(smp_left), .smp_r(smp_right), .stat_l(stat_left),
    .stat_r(stat_right), .blk(blk_start), .sdata(sdata)
  );

  assign sck_out = cfg_master ? (m_sck ^ cfg_bpol) : 1'b0;
  assign wck_out = cfg_master ? (m_wck ^ cfg_wpol) : 1'b0;

endmodule

// File: rtl/sao_tx_chk.sv
module sao_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_mute,
  input logic cfg_bpol,
  input logic cfg_wpol,
  input logic sck_out,
  input logic wck_out,
  input logic sdata,
  input logic bit_adv
);

  AST_SLAVE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!sck_out && !wck_out)); // R9

  AST_DATA_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(bit_adv)); // R6

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_adv && cfg_mute) |=> !sdata); // R8

  AST_WCK_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && $stable(cfg_wpol) && !$stable(wck_out))
      |-> $past(bit_adv)); // R1

  AST_SCK_LOW_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_adv && cfg_master) |=> (!cfg_master || (sck_out == cfg_bpol))); // R6

endmodule

bind sao_tx sao_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_mute(cfg_mute),
  .cfg_bpol(cfg_bpol), .cfg_wpol(cfg_wpol), .sck_out(sck_out),
  .wck_out(wck_out), .sdata(sdata), .bit_adv(bit_adv)
);

// File: tb/test_sao_tx.sv
module test_sao_tx;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b0;
  logic [1:0]  cfg_res = 2'd2;
  logic        cfg_rjust = 1'b0, cfg_dly = 1'b0, cfg_bpol = 1'b0, cfg_wpol = 1'b0;
  logic        cfg_mute = 1'b0, cfg_direct = 1'b0;
  logic [23:0] smp_left = 24'h9A5C3E, smp_right = 24'h3B7E01;
  logic [2:0]  stat_left = 3'b101, stat_right = 3'b010;
  logic        blk_start = 1'b0;
  logic        sck_in = 1'b0, wck_in = 1'b0;
  logic        sck_out, wck_out, sdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sao_tx i_sao_tx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_res(cfg_res),
    .cfg_rjust(cfg_rjust), .cfg_dly(cfg_dly), .cfg_bpol(cfg_bpol),
    .cfg_wpol(cfg_wpol), .cfg_mute(cfg_mute), .cfg_direct(cfg_direct),
    .smp_left(smp_left), .smp_right(smp_right), .stat_left(stat_left),
    .stat_right(stat_right), .blk_start(blk_start), .sck_in(sck_in),
    .wck_in(wck_in), .sck_out(sck_out), .wck_out(wck_out), .sdata(sdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Expected 32-slot image of one channel phase, bit 31 = slot 0
  function automatic logic [31:0] expv(input logic [23:0] s, input logic [1:0] res,
                                       input logic rj, input logic dly, input logic dir,
                                       input logic [2:0] vuc, input logic z);
    int n;
    logic [31:0] w;
    n = (res == 2'd0) ? 16 : (res == 2'd1) ? 20 : 24;
    if (dir) begin
      w = {s, vuc, z, 4'b0000};
      return w >> dly;
    end
    w = {8'h00, s} >> (24 - n);
    if (rj) return w;
    return (w << (32 - n)) >> dly;
  endfunction

  function automatic logic sn();
    return sck_out ^ cfg_bpol;
  endfunction

  function automatic logic wn();
    return wck_out ^ cfg_wpol;
  endfunction

  // Decode one master-mode channel phase at the port
  task automatic cap_master(input logic want_right, input int mute_at, input int chg_at,
                            output logic [31:0] got);
    logic pw, ps, w, s;
    int k;
    got = '0;
    pw = wn();
    forever begin
      @(negedge clk);
      w = wn();
      if (w == want_right && pw != want_right) break;
      pw = w;
    end
    ps = sn();
    k = 0;
    while (k < 32) begin
      @(negedge clk);
      s = sn();
      if (s && !ps) begin
        got[31-k] = sdata;
        if (k == mute_at) cfg_mute = 1'b1;
        if (k == chg_at) smp_left = ~smp_left;
        k++;
      end
      ps = s;
    end
  endtask

  task automatic slave_frame(input int nclk, output logic [31:0] gl, output logic [31:0] gr);
    gl = '0;
    gr = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < nclk; b++) begin
        sck_in = cfg_bpol;
        if (b == 0) wck_in = (ch == 1) ^ cfg_wpol;
        repeat (HALF) @(negedge clk);
        if (b < 32) begin
          if (ch == 0) gl[31-b] = sdata; else gr[31-b] = sdata;
        end
        sck_in = ~cfg_bpol;
        repeat (HALF) @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk("R9 reset sdata", {31'd0, sdata}, 32'd0);
    chk("R9 slave pins idle", {30'd0, sck_out, wck_out}, 32'd0);
  endtask

  task automatic t_clocks();
    int c;
    logic ps;
    cfg_master = 1'b1;
    ps = sn();
    forever begin @(negedge clk); if (sn() && !ps) break; ps = sn(); end
    c = 0;
    ps = 1'b1;
    forever begin @(negedge clk); c++; if (sn() && !ps) break; ps = sn(); end
    chk("R1 sck period", c, 4);
    while (wn() != 1'b0) @(negedge clk);
    while (wn() != 1'b1) @(negedge clk);
    c = 0;
    while (wn() == 1'b1) begin @(negedge clk); c++; end
    chk("R1 wck phase length", c, 128);
  endtask

  task automatic t_lj();
    logic [31:0] g;
    for (int r = 0; r < 3; r++) begin
      cfg_res = 2'(r);
      cap_master(1'b0, -1, -1, g);
      chk("R2 left-aligned left", g, expv(smp_left, cfg_res, 0, 0, 0, 0, 0));
      cap_master(1'b1, -1, -1, g);
      chk("R5 right channel", g, expv(smp_right, cfg_res, 0, 0, 0, 0, 0));
    end
  endtask

  task automatic t_dly();
    logic [31:0] g;
    cfg_res = 2'd3;
    cfg_dly = 1'b1;
    cap_master(1'b0, -1, -1, g);
    chk("R3 delayed first bit", g, expv(smp_left, 2'd2, 0, 1, 0, 0, 0));
  endtask

  task automatic t_rj();
    logic [31:0] g;
    cfg_rjust = 1'b1;
    cfg_res = 2'd0;
    cap_master(1'b0, -1, -1, g);
    chk("R4 right-aligned 16", g, expv(smp_left, 2'd0, 1, 0, 0, 0, 0));
    cfg_res = 2'd1;
    cap_master(1'b1, -1, -1, g);
    chk("R4 right-aligned 20", g, expv(smp_right, 2'd1, 1, 0, 0, 0, 0));
    cfg_rjust = 1'b0;
    cfg_dly = 1'b0;
  endtask

  task automatic t_pol();
    logic [31:0] g;
    cfg_res = 2'd2;
    cfg_bpol = 1'b1;
    cfg_wpol = 1'b1;
    cap_master(1'b0, -1, -1, g);
    chk("R5 R6 inverted left", g, expv(smp_left, 2'd2, 0, 0, 0, 0, 0));
    cap_master(1'b1, -1, -1, g);
    chk("R5 R6 inverted right", g, expv(smp_right, 2'd2, 0, 0, 0, 0, 0));
    cfg_bpol = 1'b0;
    cfg_wpol = 1'b0;
  endtask

  task automatic t_direct();
    logic [31:0] g;
    cfg_direct = 1'b1;
    cfg_res = 2'd0;
    cfg_rjust = 1'b1;
    cfg_dly = 1'b1;
    blk_start = 1'b1;
    cap_master(1'b0, -1, -1, g);
    chk("R7 direct left", g, expv(smp_left, 0, 0, 1, 1, stat_left, 1'b1));
    cap_master(1'b1, -1, -1, g);
    chk("R7 direct right", g, expv(smp_right, 0, 0, 1, 1, stat_right, 1'b1));
    blk_start = 1'b0;
    cfg_dly = 1'b0;
    cap_master(1'b0, -1, -1, g);
    chk("R7 direct no marker", g, expv(smp_left, 0, 0, 0, 1, stat_left, 1'b0));
    cfg_direct = 1'b0;
    cfg_rjust = 1'b0;
    cfg_res = 2'd2;
  endtask

  task automatic t_mute();
    logic [31:0] g;
    cap_master(1'b0, 10, -1, g);
    chk("R8 mute mid-word", g, expv(smp_left, 2'd2, 0, 0, 0, 0, 0) & 32'hFFE0_0000);
    cfg_mute = 1'b0;
  endtask

  task automatic t_latch();
    logic [31:0] g;
    logic [23:0] orig;
    orig = smp_left;
    cap_master(1'b0, -1, 3, g);
    chk("R12 sample latched", g, expv(orig, 2'd2, 0, 0, 0, 0, 0));
    smp_left = orig;
  endtask

  task automatic t_slave();
    logic [31:0] gl, gr;
    cfg_master = 1'b0;
    cfg_res = 2'd2;
    cfg_dly = 1'b1;
    sck_in = 1'b1;
    wck_in = 1'b1;
    repeat (10) @(negedge clk);
    slave_frame(32, gl, gr);
    slave_frame(32, gl, gr);
    chk("R9 slave left", gl, expv(smp_left, 2'd2, 0, 1, 0, 0, 0));
    chk("R9 slave right", gr, expv(smp_right, 2'd2, 0, 1, 0, 0, 0));
    chk("R9 slave pins idle", {30'd0, sck_out, wck_out}, 32'd0);
    cfg_rjust = 1'b1;
    cfg_res = 2'd0;
    slave_frame(32, gl, gr);
    slave_frame(32, gl, gr);
    chk("R10 slave refuses right align", gl, expv(smp_left, 2'd0, 0, 1, 0, 0, 0));
    cfg_rjust = 1'b0;
    cfg_dly = 1'b0;
    cfg_bpol = 1'b1;
    cfg_wpol = 1'b1;
    sck_in = 1'b0;
    wck_in = 1'b0;
    repeat (10) @(negedge clk);
    slave_frame(18, gl, gr);
    slave_frame(18, gl, gr);
    chk("R11 short phase left", gl & 32'hFFFF_C000,
        expv(smp_left, 2'd0, 0, 0, 0, 0, 0) & 32'hFFFF_C000);
    chk("R11 short phase right", gr & 32'hFFFF_C000,
        expv(smp_right, 2'd0, 0, 0, 0, 0, 0) & 32'hFFFF_C000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clocks();
    t_lj();
    t_dly();
    t_rj();
    t_pol();
    t_direct();
    t_mute();
    t_latch();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule